// File: doc/BRIEF.md
# USB Device IN Endpoint Responder

This block answers IN tokens for one IN endpoint of a USB device controller. It keeps the endpoint's control state: enabled or not, NAK mode, and whether the endpoint is isochronous. It owns a transmit FIFO that holds whole packets. Firmware first announces a packet with a length header. The header is accepted only when the whole packet fits. The data words follow on a valid/ready stream. A separate queue of lengths keeps packet boundaries, so every IN token sends exactly one packet.

For each IN token the block picks one of three answers: the packet at the head of the queue, a NAK handshake, or a zero-length packet. It picks NAK when the endpoint is not isochronous and ZLP when it is. A NAK or ZLP answer is given when the endpoint is in NAK mode, disabled, or has no complete packet. A data packet on a non-isochronous endpoint stays in the FIFO until the host acknowledges it. If the host times out instead, the same packet is sent again with the same data PID. An isochronous packet is released as soon as it has been sent.

The block has three interrupt outputs: NAK-effective, FIFO-empty and transfer-complete. It also reports the number of free words in the FIFO.

Top module: `usb_in_ep_responder`

## Requirements
- R1: While NAK mode is in effect, an IN token on a non-isochronous endpoint is answered with kind NAK (`resp_kind` = 1) and no data, even if complete packets are queued.
- R2: While NAK mode is in effect, an IN token on an isochronous endpoint is answered with kind ZLP (`resp_kind` = 2).
- R3: A `nak_set` pulse puts the endpoint into NAK mode and raises `irq_nak_eff`, but only once the responder is idle. If a packet is waiting for its handshake, both are held back until that transaction ends.
- R4: A `nak_clr` pulse ends NAK mode and clears `irq_nak_eff`. Nothing else clears that flag.
- R5: `free_words` equals DEPTH minus the words reserved by accepted headers that have not yet been released. `irq_txe` is high exactly when that count of reserved words is zero. After reset these are DEPTH and 1.
- R6: A header with nonzero length is accepted (`hdr_ready` = 1) only if its length is at most `free_words`. A header with zero length needs no free space.
- R7: A non-isochronous endpoint accepts several queued packets, up to the depth of the length queue. An isochronous endpoint accepts a new header only when no packet is queued.
- R8: Headers are refused while the endpoint is disabled. `ep_en_set` sets only the enable and keeps the type and NAK mode. `cfg_wr` loads the type from `cfg_iso`, clears the enable and resets the data PID to DATA0.
- R9: An IN token answered with data sends exactly the head packet: `resp_kind` = 0 (DATA), `resp_len` = the head length, then that many words in the order they were written, with `tx_last` set on the final word.
- R10: An IN token on a disabled endpoint, or on an endpoint with no completely written packet, is answered with NAK if the endpoint is non-isochronous and with ZLP if it is isochronous.
- R11: `irq_xfer_done` pulses for one cycle when the last queued packet is released. On a non-isochronous endpoint that happens at the handshake; on an isochronous endpoint it happens when the final word is sent.
- R12: On a non-isochronous endpoint, `resp_pid` (0 = DATA0, 1 = DATA1) toggles for each acknowledged packet. After `hs_timeout` the packet stays queued, and the next token sends the same data with the same PID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load endpoint type, disable endpoint, reset PID |
| cfg_iso | input | 1 | Endpoint type loaded by cfg_wr (1 = isochronous) |
| ep_en_set | input | 1 | Set endpoint enable only |
| nak_set | input | 1 | Request NAK mode |
| nak_clr | input | 1 | Leave NAK mode and clear the NAK-effective flag |
| hdr_valid | input | 1 | Packet header offered |
| hdr_len | input | LW | Packet length in words |
| hdr_ready | output | 1 | Header accepted this cycle if valid |
| wr_valid | input | 1 | Packet data word offered |
| wr_data | input | DW | Packet data word |
| wr_ready | output | 1 | Data word accepted if valid |
| tok_in | input | 1 | IN token received (one-cycle pulse) |
| resp_valid | output | 1 | Response descriptor valid |
| resp_kind | output | 2 | 0 DATA, 1 NAK, 2 ZLP |
| resp_pid | output | 1 | Data PID, 0 DATA0, 1 DATA1 |
| resp_len | output | LW | Packet length for DATA responses |
| resp_ready | input | 1 | Response descriptor taken |
| tx_valid | output | 1 | Outgoing data word valid |
| tx_data | output | DW | Outgoing data word |
| tx_last | output | 1 | Final word of the packet |
| tx_ready | input | 1 | Outgoing word taken |
| hs_ack | input | 1 | Host acknowledged the packet |
| hs_timeout | input | 1 | Host handshake missing |
| free_words | output | LW | Free words in the transmit FIFO |
| irq_txe | output | 1 | Transmit FIFO empty |
| irq_nak_eff | output | 1 | NAK mode has taken effect |
| irq_xfer_done | output | 1 | Last queued packet released (pulse) |

## Verification
The hardest case to reach is a NAK request that arrives while a packet has been sent but not yet acknowledged. The NAK must not take effect until the handshake ends. To reach it, the stimulus streams a one-word packet out and then holds off `hs_ack` while it pulses `nak_set`. It checks that the flag stays low, and only then delivers the acknowledgement. A second hard case is a replay after a handshake timeout. The stimulus sends a packet, signals `hs_timeout`, and checks three things: the free space is unchanged, the second token returns the same words, and the PID has not moved.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    typedef enum logic [1:0] {
        RESP_DATA = 2'd0,
        RESP_NAK  = 2'd1,
        RESP_ZLP  = 2'd2
    } resp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RESP     = 2'd1,
        ST_SEND     = 2'd2,
        ST_WAIT_ACK = 2'd3
    } resp_state_e;

endpackage

// File: rtl/usb_in_ep_ctl.sv
module usb_in_ep_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_iso,
    input  logic ep_en_set,
    input  logic nak_set,
    input  logic nak_clr,
    input  logic idle,
    output logic enabled,
    output logic iso,
    output logic nak_mode,
    output logic nak_eff_irq
);

    typedef struct packed {
        logic en;
        logic iso;
        logic nak;
        logic pend;
        logic irq;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.iso = cfg_iso;
            st_d.en  = 1'b0;
        end
        if (ep_en_set) begin
            st_d.en = 1'b1;
        end
        if (nak_set) begin
            st_d.pend = 1'b1;
        end
        // the request only becomes effective between transactions
        if (st_q.pend && idle) begin
            st_d.nak  = 1'b1;
            st_d.irq  = 1'b1;
            st_d.pend = 1'b0;
        end
        if (nak_clr) begin
            st_d.nak  = 1'b0;
            st_d.pend = 1'b0;
            st_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enabled     = st_q.en;
    assign iso         = st_q.iso;
    assign nak_mode    = st_q.nak;
    assign nak_eff_irq = st_q.irq;

    assert_nak_eff_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(idle));

    assert_nak_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nak_clr |=> (!st_q.nak && !st_q.irq));

endmodule

// File: rtl/usb_in_ep_txfifo.sv
module usb_in_ep_txfifo #(
    parameter int DW       = 32,
    parameter int DEPTH    = 16,
    parameter int LQ_DEPTH = 4,
    parameter int LW       = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enabled,
    input  logic          iso,
    input  logic          hdr_valid,
    input  logic [LW-1:0] hdr_len,
    output logic          hdr_ready,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          rd_adv,
    input  logic          commit,
    input  logic          rewind,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] head_len,
    output logic          pkt_avail,
    output logic          last_pkt,
    output logic [LW-1:0] free_words,
    output logic          empty
);

    localparam int AW  = $clog2(DEPTH);
    localparam int QAW = $clog2(LQ_DEPTH);

    typedef struct packed {
        logic [AW:0]   resv;
        logic [AW:0]   wptr;
        logic [AW:0]   spec;
        logic [AW:0]   cmt;
        logic [LW-1:0] remain;
        logic [QAW:0]  qwr;
        logic [QAW:0]  qrd;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    logic [DW-1:0] mem    [DEPTH];
    logic [LW-1:0] lq_mem [LQ_DEPTH];

    logic [QAW:0]  lq_cnt;
    logic [AW:0]   used;
    logic          hdr_fire;
    logic          wr_fire;

    assign lq_cnt     = st_q.qwr - st_q.qrd;
    assign used       = st_q.resv - st_q.cmt;
    assign free_words = LW'(DEPTH) - used;
    assign empty      = (used == '0);

    assign hdr_ready = enabled
                    && (st_q.remain == '0)
                    && (lq_cnt != (QAW+1)'(LQ_DEPTH))
                    && ((hdr_len == '0) || (hdr_len <= free_words))
                    && (!iso || (lq_cnt == '0));
    assign wr_ready  = (st_q.remain != '0);
    assign hdr_fire  = hdr_valid && hdr_ready;
    assign wr_fire   = wr_valid && wr_ready;

    // a packet still being written is queued but not yet sendable
    assign pkt_avail = lq_cnt > (QAW+1)'(st_q.remain != '0);
    assign last_pkt  = (lq_cnt == (QAW+1)'(1));
    assign head_len  = lq_mem[st_q.qrd[QAW-1:0]];
    assign rd_data   = mem[st_q.spec[AW-1:0]];

    always_comb begin
        st_d = st_q;
        if (hdr_fire) begin
            st_d.resv   = st_q.resv + hdr_len;
            st_d.remain = hdr_len;
            st_d.qwr    = st_q.qwr + 1'b1;
        end
        if (wr_fire) begin
            st_d.wptr   = st_q.wptr + 1'b1;
            st_d.remain = st_q.remain - 1'b1;
        end
        if (rewind) begin
            st_d.spec = st_q.cmt;
        end else if (rd_adv) begin
            st_d.spec = st_q.spec + 1'b1;
        end
        if (commit) begin
            st_d.cmt = st_d.spec;
            st_d.qrd = st_q.qrd + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[st_q.wptr[AW-1:0]] <= wr_data;
        end
        if (hdr_fire) begin
            lq_mem[st_q.qwr[QAW-1:0]] <= hdr_len;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.resv - st_q.cmt) <= (AW+1)'(DEPTH));

    assert_iso_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iso && lq_cnt <= (QAW+1)'(1)) |=> (!iso || lq_cnt <= (QAW+1)'(1)));

    assert_release_whole_pkt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (LW'(st_d.spec - st_q.cmt) == head_len));

endmodule

// File: rtl/usb_in_ep_fsm.sv
module usb_in_ep_fsm
    import usb_in_ep_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic          enabled,
    input  logic          iso,
    input  logic          nak_mode,
    input  logic          cfg_wr,
    input  logic          pkt_avail,
    input  logic [LW-1:0] head_len,
    input  logic          last_pkt,
    input  logic          resp_ready,
    input  logic          tx_ready,
    input  logic          hs_ack,
    input  logic          hs_timeout,
    output logic          resp_valid,
    output logic [1:0]    resp_kind,
    output logic          resp_pid,
    output logic [LW-1:0] resp_len,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          rd_adv,
    output logic          commit,
    output logic          rewind,
    output logic          idle,
    output logic          xfer_done
);

    typedef struct packed {
        resp_state_e   state;
        resp_kind_e    kind;
        logic [LW-1:0] len;
        logic [LW-1:0] cnt;
        logic          pid;
        logic          done;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    end_pkt;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        rd_adv    = 1'b0;
        commit    = 1'b0;
        rewind    = 1'b0;
        end_pkt   = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (tok_in) begin
                    st_d.state = ST_RESP;
                    if (enabled && !nak_mode && pkt_avail) begin
                        st_d.kind = RESP_DATA;
                        st_d.len  = head_len;
                    end else begin
                        st_d.kind = iso ? RESP_ZLP : RESP_NAK;
                        st_d.len  = '0;
                    end
                end
            end
            ST_RESP: begin
                if (resp_ready) begin
                    if (st_q.kind != RESP_DATA) begin
                        st_d.state = ST_IDLE;
                    end else if (st_q.len == '0) begin
                        end_pkt = 1'b1;
                    end else begin
                        st_d.state = ST_SEND;
                        st_d.cnt   = st_q.len;
                    end
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    rd_adv   = 1'b1;
                    st_d.cnt = st_q.cnt - 1'b1;
                    if (st_q.cnt == LW'(1)) begin
                        end_pkt = 1'b1;
                    end
                end
            end
            ST_WAIT_ACK: begin
                if (hs_ack) begin
                    commit     = 1'b1;
                    st_d.pid   = ~st_q.pid;
                    st_d.done  = last_pkt;
                    st_d.state = ST_IDLE;
                end else if (hs_timeout) begin
                    rewind     = 1'b1;
                    st_d.state = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
        if (end_pkt) begin
            if (iso) begin
                // no handshake phase: release immediately
                commit     = 1'b1;
                st_d.done  = last_pkt;
                st_d.state = ST_IDLE;
            end else begin
                st_d.state = ST_WAIT_ACK;
            end
        end
        if (cfg_wr) begin
            st_d.pid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, kind: RESP_NAK, len: '0, cnt: '0, pid: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = (st_q.state == ST_RESP);
    assign resp_kind  = st_q.kind;
    assign resp_pid   = st_q.pid;
    assign resp_len   = st_q.len;
    assign tx_valid   = (st_q.state == ST_SEND);
    assign tx_last    = (st_q.cnt == LW'(1));
    assign idle       = (st_q.state == ST_IDLE);
    assign xfer_done  = st_q.done;

    assert_nak_no_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE && tok_in && nak_mode) |=> (st_q.kind != RESP_DATA));

    assert_iso_zlp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE && tok_in && nak_mode && iso) |=> (st_q.kind == RESP_ZLP));

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);

    assert_replay_pid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_WAIT_ACK && !hs_ack && hs_timeout && !cfg_wr) |=> $stable(st_q.pid));

endmodule

// File: rtl/usb_in_ep_responder.sv
module usb_in_ep_responder #(
    parameter int DW       = 32,
    parameter int DEPTH    = 16,
    parameter int LQ_DEPTH = 4,
    parameter int LW       = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_iso,
    input  logic          ep_en_set,
    input  logic          nak_set,
    input  logic          nak_clr,
    input  logic          hdr_valid,
    input  logic [LW-1:0] hdr_len,
    output logic          hdr_ready,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          tok_in,
    output logic          resp_valid,
    output logic [1:0]    resp_kind,
    output logic          resp_pid,
    output logic [LW-1:0] resp_len,
    input  logic          resp_ready,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          hs_ack,
    input  logic          hs_timeout,
    output logic [LW-1:0] free_words,
    output logic          irq_txe,
    output logic          irq_nak_eff,
    output logic          irq_xfer_done
);

    logic          enabled;
    logic          iso;
    logic          nak_mode;
    logic          idle;
    logic          rd_adv;
    logic          commit;
    logic          rewind;
    logic          pkt_avail;
    logic          last_pkt;
    logic [LW-1:0] head_len;

    usb_in_ep_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_iso     (cfg_iso),
        .ep_en_set   (ep_en_set),
        .nak_set     (nak_set),
        .nak_clr     (nak_clr),
        .idle        (idle),
        .enabled     (enabled),
        .iso         (iso),
        .nak_mode    (nak_mode),
        .nak_eff_irq (irq_nak_eff)
    );

    usb_in_ep_txfifo #(
        .DW       (DW),
        .DEPTH    (DEPTH),
        .LQ_DEPTH (LQ_DEPTH),
        .LW       (LW)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .enabled    (enabled),
        .iso        (iso),
        .hdr_valid  (hdr_valid),
        .hdr_len    (hdr_len),
        .hdr_ready  (hdr_ready),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .rd_adv     (rd_adv),
        .commit     (commit),
        .rewind     (rewind),
        .rd_data    (tx_data),
        .head_len   (head_len),
        .pkt_avail  (pkt_avail),
        .last_pkt   (last_pkt),
        .free_words (free_words),
        .empty      (irq_txe)
    );

    usb_in_ep_fsm #(
        .LW (LW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_in     (tok_in),
        .enabled    (enabled),
        .iso        (iso),
        .nak_mode   (nak_mode),
        .cfg_wr     (cfg_wr),
        .pkt_avail  (pkt_avail),
        .head_len   (head_len),
        .last_pkt   (last_pkt),
        .resp_ready (resp_ready),
        .tx_ready   (tx_ready),
        .hs_ack     (hs_ack),
        .hs_timeout (hs_timeout),
        .resp_valid (resp_valid),
        .resp_kind  (resp_kind),
        .resp_pid   (resp_pid),
        .resp_len   (resp_len),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .rd_adv     (rd_adv),
        .commit     (commit),
        .rewind     (rewind),
        .idle       (idle),
        .xfer_done  (irq_xfer_done)
    );

    assert_txe_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_txe |-> (free_words == LW'(DEPTH)));

endmodule

// File: tb/usb_in_ep_responder_tb.sv
module usb_in_ep_responder_tb;

    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int LQ_DEPTH = 4;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 0, cfg_iso = 0, ep_en_set = 0, nak_set = 0, nak_clr = 0;
    logic          hdr_valid = 0;
    logic [LW-1:0] hdr_len = '0;
    logic          hdr_ready;
    logic          wr_valid = 0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;
    logic          tok_in = 0;
    logic          resp_valid;
    logic [1:0]    resp_kind;
    logic          resp_pid;
    logic [LW-1:0] resp_len;
    logic          resp_ready = 0;
    logic          tx_valid;
    logic [DW-1:0] tx_data;
    logic          tx_last;
    logic          tx_ready = 0;
    logic          hs_ack = 0, hs_timeout = 0;
    logic [LW-1:0] free_words;
    logic          irq_txe, irq_nak_eff, irq_xfer_done;

    always #10 clk = ~clk;

    usb_in_ep_responder #(.DW(DW), .DEPTH(DEPTH), .LQ_DEPTH(LQ_DEPTH), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_iso(cfg_iso), .ep_en_set(ep_en_set),
        .nak_set(nak_set), .nak_clr(nak_clr), .hdr_valid(hdr_valid), .hdr_len(hdr_len),
        .hdr_ready(hdr_ready), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .tok_in(tok_in), .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_pid(resp_pid),
        .resp_len(resp_len), .resp_ready(resp_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .hs_ack(hs_ack), .hs_timeout(hs_timeout),
        .free_words(free_words), .irq_txe(irq_txe), .irq_nak_eff(irq_nak_eff),
        .irq_xfer_done(irq_xfer_done)
    );

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct packed {
        logic          op;     // 0 push header+data, 1 token (+ack on data)
        logic [LW-1:0] len;
        logic [15:0]   base;
        logic          ok;
        logic [1:0]    kind;
        logic          pid;
        logic          done;
        logic [LW-1:0] free;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd5, 16'd100, 1'b1, 2'd0, 1'b0, 1'b0, 5'd11},
        '{1'b0, 5'd8, 16'd200, 1'b1, 2'd0, 1'b0, 1'b0, 5'd3},
        '{1'b0, 5'd4, 16'd250, 1'b0, 2'd0, 1'b0, 1'b0, 5'd3},
        '{1'b0, 5'd3, 16'd300, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0},
        '{1'b0, 5'd0, 16'd0,   1'b1, 2'd0, 1'b0, 1'b0, 5'd0},
        '{1'b1, 5'd5, 16'd100, 1'b1, 2'd0, 1'b0, 1'b0, 5'd5},
        '{1'b1, 5'd8, 16'd200, 1'b1, 2'd0, 1'b1, 1'b0, 5'd13},
        '{1'b0, 5'd2, 16'd400, 1'b1, 2'd0, 1'b0, 1'b0, 5'd11},
        '{1'b1, 5'd3, 16'd300, 1'b1, 2'd0, 1'b0, 1'b0, 5'd14},
        '{1'b1, 5'd0, 16'd0,   1'b1, 2'd0, 1'b1, 1'b0, 5'd14},
        '{1'b1, 5'd2, 16'd400, 1'b1, 2'd0, 1'b0, 1'b1, 5'd16},
        '{1'b1, 5'd0, 16'd0,   1'b1, 2'd1, 1'b0, 1'b0, 5'd16}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic push(input logic [LW-1:0] len, input logic [15:0] base, output bit ok);
        @(negedge clk);
        hdr_valid = 1'b1;
        hdr_len   = len;
        #1 ok = hdr_ready;
        @(negedge clk);
        hdr_valid = 1'b0;
        if (ok) begin
            for (int i = 0; i < int'(len); i++) begin
                wr_valid = 1'b1;
                wr_data  = 32'(base) + 32'(i);
                @(negedge clk);
            end
            wr_valid = 1'b0;
        end
    endtask

    // issue a token, take the descriptor, stream out and check any data words
    task automatic token(input string tag, input logic [15:0] base,
                         output logic [1:0] kind, output logic pid,
                         output logic [LW-1:0] len, output logic done);
        @(negedge clk);
        tok_in = 1'b1;
        @(negedge clk);
        tok_in = 1'b0;
        #1;
        chk({tag, " resp_valid"}, 32'(resp_valid), 32'd1);
        kind = resp_kind;
        pid  = resp_pid;
        len  = resp_len;
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        done = irq_xfer_done;
        if (kind == 2'd0 && len != '0) begin
            tx_ready = 1'b1;
            for (int i = 0; i < int'(len); i++) begin
                #1;
                chk({tag, " tx word"}, tx_data, 32'(base) + 32'(i));
                chk({tag, " tx_last"}, 32'(tx_last), 32'(i == int'(len) - 1));
                @(negedge clk);
            end
            tx_ready = 1'b0;
            done = irq_xfer_done;
        end
    endtask

    task automatic ack(output logic done);
        hs_ack = 1'b1;
        @(negedge clk);
        hs_ack = 1'b0;
        done = irq_xfer_done;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        bit            ok;
        logic [1:0]    k;
        logic          p;
        logic [LW-1:0] l;
        logic          dn;
        logic          exp_pid;
        exp_pid = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R5)
        chk("R5 reset free_words", 32'(free_words), 32'd16);
        chk("R5 reset irq_txe", 32'(irq_txe), 32'd1);
        chk("R3 reset irq_nak_eff", 32'(irq_nak_eff), 32'd0);
        chk("R9 reset resp_valid", 32'(resp_valid), 32'd0);

        // disabled endpoint (R8, R10)
        push(5'd2, 16'd10, ok);
        chk("R8 header refused while disabled", 32'(ok), 32'd0);
        token("R10 disabled token", 16'd0, k, p, l, dn);
        chk("R10 disabled non-iso kind", 32'(k), 32'd1);

        pulse(ep_en_set);

        // table walk (R6, R7, R9, R11, R12)
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].op == 1'b0) begin
                push(VECS[v].len, VECS[v].base, ok);
                chk($sformatf("R6/R7 push accept v%0d", v), 32'(ok), 32'(VECS[v].ok));
            end else begin
                token($sformatf("R9 token v%0d", v), VECS[v].base, k, p, l, dn);
                chk($sformatf("R9/R10 kind v%0d", v), 32'(k), 32'(VECS[v].kind));
                if (k == 2'd0) begin
                    chk($sformatf("R9 len v%0d", v), 32'(l), 32'(VECS[v].len));
                    chk($sformatf("R12 pid v%0d", v), 32'(p), 32'(VECS[v].pid));
                    ack(dn);
                    exp_pid = ~exp_pid;
                    chk($sformatf("R11 xfer_done v%0d", v), 32'(dn), 32'(VECS[v].done));
                end
            end
            chk($sformatf("R5 free_words v%0d", v), 32'(free_words), 32'(VECS[v].free));
        end
        chk("R5 irq_txe after drain", 32'(irq_txe), 32'd1);

        // NAK overrides queued data (R1, R3, R4)
        push(5'd2, 16'd600, ok);
        chk("R5 irq_txe with data", 32'(irq_txe), 32'd0);
        pulse(nak_set);
        repeat (2) @(negedge clk);
        chk("R3 nak effective in idle", 32'(irq_nak_eff), 32'd1);
        token("R1 nak token", 16'd0, k, p, l, dn);
        chk("R1 nak kind", 32'(k), 32'd1);
        chk("R1 data kept", 32'(free_words), 32'd14);
        pulse(nak_clr);
        chk("R4 nak_clr clears flag", 32'(irq_nak_eff), 32'd0);
        token("R4 after clear", 16'd600, k, p, l, dn);
        chk("R4 data after clear", 32'(k), 32'd0);
        chk("R12 pid continues", 32'(p), 32'(exp_pid));
        ack(dn);
        exp_pid = ~exp_pid;
        chk("R11 done on last ack", 32'(dn), 32'd1);

        // NAK deferred during pending handshake (R3)
        push(5'd1, 16'd700, ok);
        token("R3 pending data", 16'd700, k, p, l, dn);
        chk("R3 data sent", 32'(k), 32'd0);
        nak_set = 1'b1;
        @(negedge clk);
        nak_set = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 nak held while awaiting ack", 32'(irq_nak_eff), 32'd0);
        ack(dn);
        exp_pid = ~exp_pid;
        repeat (2) @(negedge clk);
        chk("R3 nak effective after ack", 32'(irq_nak_eff), 32'd1);
        token("R1 nak after deferral", 16'd0, k, p, l, dn);
        chk("R1 nak kind after deferral", 32'(k), 32'd1);
        pulse(nak_clr);

        // timeout replay (R12)
        push(5'd2, 16'd800, ok);
        token("R12 first try", 16'd800, k, p, l, dn);
        chk("R12 first try pid", 32'(p), 32'(exp_pid));
        hs_timeout = 1'b1;
        @(negedge clk);
        hs_timeout = 1'b0;
        chk("R12 space kept after timeout", 32'(free_words), 32'd14);
        token("R12 replay", 16'd800, k, p, l, dn);
        chk("R12 replay len", 32'(l), 32'd2);
        chk("R12 replay same pid", 32'(p), 32'(exp_pid));
        ack(dn);
        exp_pid = ~exp_pid;
        push(5'd1, 16'd850, ok);
        token("R12 next packet", 16'd850, k, p, l, dn);
        chk("R12 pid toggled", 32'(p), 32'(exp_pid));
        ack(dn);

        // isochronous endpoint (R2, R7, R8, R10, R11)
        cfg_iso = 1'b1;
        pulse(cfg_wr);
        cfg_iso = 1'b0;
        token("R10 iso disabled", 16'd0, k, p, l, dn);
        chk("R10 iso disabled zlp", 32'(k), 32'd2);
        push(5'd3, 16'd900, ok);
        chk("R8 cfg_wr cleared enable", 32'(ok), 32'd0);
        pulse(ep_en_set);
        push(5'd3, 16'd900, ok);
        chk("R7 iso first packet", 32'(ok), 32'd1);
        push(5'd1, 16'd950, ok);
        chk("R7 iso second packet refused", 32'(ok), 32'd0);
        token("R11 iso data", 16'd900, k, p, l, dn);
        chk("R9 iso data kind", 32'(k), 32'd0);
        chk("R8 cfg_wr reset pid", 32'(p), 32'd0);
        chk("R11 iso done without ack", 32'(dn), 32'd1);
        chk("R5 iso released", 32'(free_words), 32'd16);
        pulse(nak_set);
        repeat (2) @(negedge clk);
        push(5'd2, 16'd960, ok);
        token("R2 iso nak", 16'd0, k, p, l, dn);
        chk("R2 iso nak zlp", 32'(k), 32'd2);
        pulse(ep_en_set);
        token("R8 enable keeps nak", 16'd0, k, p, l, dn);
        chk("R8 enable keeps nak and type", 32'(k), 32'd2);
        chk("R8 flag kept", 32'(irq_nak_eff), 32'd1);
        pulse(nak_clr);
        token("R9 iso after clear", 16'd960, k, p, l, dn);
        chk("R9 iso after clear kind", 32'(k), 32'd0);
        token("R10 iso empty", 16'd0, k, p, l, dn);
        chk("R10 iso empty zlp", 32'(k), 32'd2);

        summary();
        $finish;
    end

endmodule